// File: doc/BRIEF.md
# Three-Register Dedicated-Multiplexer Transfer Datapath

This block holds three registers of parameterised width. In front of every register sits a private two-input source selector, steered by that register's own select bit, and every register has its own load enable. Since no path is shared, one clock edge can carry out any mix of transfers. Several destinations may take the same source. Different destinations may take different sources, so swaps and three-way rotations complete in one cycle.

A side write port loads a chosen register with external data, for initialisation. When its address names a register, that register takes the port data and ignores its transfer load in the same cycle. The registers drive the outputs directly. A synchronous active-high reset clears every register.

Top module: `dmux_xfer_unit`

## Requirements
- R1: When `rst` is high at a rising edge, all three registers become zero after that edge.
- R2: A register whose load bit is low, and which the write port does not address, keeps its value across the edge.
- R3: When a register's load bit is high, it takes the pre-edge value of a source chosen by its own select bit. Register 0 takes register 1 on 0 and register 2 on 1. Register 1 takes register 0 on 0 and register 2 on 1. Register 2 takes register 0 on 0 and register 1 on 1.
- R4: Every register samples only pre-edge values, so crossed transfers complete correctly in one cycle. Loading 0 and 1 from each other swaps them. Loading 0 from 1, 1 from 2 and 2 from 0 rotates all three.
- R5: One source can feed several destinations in one cycle. With selects (s2,s1,s0)=(0,0,x) and load bits 1 and 2 high, both registers 1 and 2 take register 0.
- R6: With `wr_en` high and `wr_addr` equal to 0, 1 or 2, the addressed register holds `wr_data` after the edge.
- R7: The write port has priority over the load bit of the register it addresses. The other registers still follow their own load and select bits in that cycle.
- R8: With `wr_en` high and `wr_addr` equal to 3, no register takes write data. Each register behaves as the load and select bits alone dictate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Bit i is the source select of register i |
| load | input | 3 | Bit i is the load enable of register i |
| wr_en | input | 1 | External write strobe |
| wr_addr | input | 2 | External write target (0..2; 3 selects nothing) |
| wr_data | input | WIDTH | External write value |
| q0 | output | WIDTH | Contents of register 0 |
| q1 | output | WIDTH | Contents of register 1 |
| q2 | output | WIDTH | Contents of register 2 |

## Verification
The bench sweeps every combination of select and load bits over several distinct data patterns. Any wrong source wiring shows up as a register that holds the contents of the wrong neighbour. Swap and rotation cases catch a design that lets a register see a value already updated in the same cycle; such a design leaves two registers holding equal contents. The write-port sweep covers every address against every load pattern. It exposes a load that overrides the write, a write that blocks the other registers' transfers, and a write to address 3 that lands in some register.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int NUM_REGS = 3;
  localparam int ADDR_W   = 2;

  // source index taken when select is 0 (lower-numbered neighbour)
  function automatic int lo_src(input int idx);
    return (idx == 0) ? 1 : 0;
  endfunction

  // source index taken when select is 1 (higher-numbered neighbour)
  function automatic int hi_src(input int idx);
    return (idx == 2) ? 1 : 2;
  endfunction
endpackage

// File: rtl/xfer_wr_decode.sv
module xfer_wr_decode
  import xfer_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int AW   = ADDR_W
) (
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  output logic [NREG-1:0] wr_hit
);
  always_comb begin
    wr_hit = '0;
    for (int k = 0; k < NREG; k++) begin
      if (wr_en && (wr_addr == AW'(k))) wr_hit[k] = 1'b1;
    end
  end
endmodule

// File: rtl/xfer_src_mux.sv
module xfer_src_mux #(
  parameter int WIDTH = 8
) (
  input  logic             pick_hi,
  input  logic [WIDTH-1:0] src_lo,
  input  logic [WIDTH-1:0] src_hi,
  output logic [WIDTH-1:0] src_out
);
  always_comb begin
    src_out = pick_hi ? src_hi : src_lo;
  end
endmodule

// File: rtl/xfer_reg_slice.sv
module xfer_reg_slice #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             ld,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (wr_hit) q <= wr_data;
    else if (ld)     q <= nxt;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> q == '0);  // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && !ld) |=> $stable(q));  // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> q == $past(wr_data));  // R7
endmodule

// File: rtl/dmux_xfer_unit.sv
module dmux_xfer_unit
  import xfer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sel,
  input  logic [2:0]        load,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  q0,
  output logic [WIDTH-1:0]  q1,
  output logic [WIDTH-1:0]  q2
);
  localparam int NREG = NUM_REGS;

  logic [NREG-1:0]  wr_hit;
  logic [WIDTH-1:0] regs [NREG];
  logic [WIDTH-1:0] nxt  [NREG];

  xfer_wr_decode #(.NREG(NREG), .AW(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_hit  (wr_hit)
  );

  for (genvar gi = 0; gi < NREG; gi++) begin : g_slot
    localparam int LO = lo_src(gi);
    localparam int HI = hi_src(gi);

    xfer_src_mux #(.WIDTH(WIDTH)) u_mux (
      .pick_hi (sel[gi]),
      .src_lo  (regs[LO]),
      .src_hi  (regs[HI]),
      .src_out (nxt[gi])
    );

    xfer_reg_slice #(.WIDTH(WIDTH)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .wr_hit  (wr_hit[gi]),
      .wr_data (wr_data),
      .ld      (load[gi]),
      .nxt     (nxt[gi]),
      .q       (regs[gi])
    );

    AST_LOAD_SOURCE: assert property (@(posedge clk) disable iff (rst)
      (load[gi] && !(wr_en && wr_addr == 2'(gi))) |=>
        regs[gi] == ($past(sel[gi]) ? $past(regs[HI]) : $past(regs[LO])));  // R3

    AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == 2'(gi)) |=> regs[gi] == $past(wr_data));  // R6
  end

  AST_DEAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd3 && load == 3'b000) |=>
      ($stable(q0) && $stable(q1) && $stable(q2)));  // R8

  AST_SWAP_PAIR: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && load == 3'b011 && sel[1:0] == 2'b00) |=>
      (q0 == $past(q1) && q1 == $past(q0)));  // R4

  assign q0 = regs[0];
  assign q1 = regs[1];
  assign q2 = regs[2];
endmodule

// File: tb/test_dmux_xfer_unit.sv
module test_dmux_xfer_unit;
  localparam int W      = 8;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [2:0]   sel;
  logic [2:0]   load;
  logic         wr_en;
  logic [1:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic [W-1:0] q0, q1, q2;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] m [3];

  always #(PERIOD/2) clk = ~clk;

  dmux_xfer_unit #(.WIDTH(W)) i_dmux_xfer_unit (
    .clk(clk), .rst(rst), .sel(sel), .load(load), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .q0(q0), .q1(q1), .q2(q2)
  );

  function automatic logic [W-1:0] outv(input int k);
    return (k == 0) ? q0 : (k == 1) ? q1 : q2;
  endfunction

  task automatic check(input string tag, input int k, input logic [W-1:0] exp);
    logic [W-1:0] act;
    act = outv(k);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s reg%0d actual=%0h expected=%0h", tag, k, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // source per requirement R3 map
  function automatic logic [W-1:0] src_of(input int k, input logic s);
    if (k == 0) return s ? m[2] : m[1];
    if (k == 1) return s ? m[2] : m[0];
    return s ? m[1] : m[0];
  endfunction

  task automatic preload(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    logic [W-1:0] v [3];
    v[0] = a; v[1] = b; v[2] = c;
    load = 3'b000; sel = 3'b000;
    for (int k = 0; k < 3; k++) begin
      wr_en = 1'b1; wr_addr = 2'(k); wr_data = v[k];
      step();
      m[k] = v[k];
    end
    wr_en = 1'b0;
    for (int k = 0; k < 3; k++) check("R6", k, m[k]);
  endtask

  // apply one transfer cycle and compare against the model
  task automatic xfer(input logic [2:0] s, input logic [2:0] l,
                      input logic we, input logic [1:0] wa, input logic [W-1:0] wd,
                      input string force_tag);
    logic [W-1:0] e [3];
    string tg;
    for (int k = 0; k < 3; k++) begin
      if (we && wa == 2'(k))  e[k] = wd;
      else if (l[k])          e[k] = src_of(k, s[k]);
      else                    e[k] = m[k];
    end
    sel = s; load = l; wr_en = we; wr_addr = wa; wr_data = wd;
    step();
    wr_en = 1'b0; load = 3'b000;
    for (int k = 0; k < 3; k++) begin
      if (force_tag != "")            tg = force_tag;
      else if (we && wa == 2'(k))     tg = "R7";
      else if (we && wa == 2'd3)      tg = "R8";
      else if (l[k])                  tg = "R3";
      else                            tg = "R2";
      check(tg, k, e[k]);
      m[k] = e[k];
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; sel = '0; load = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    step(); step();
    rst = 1'b0;
    for (int k = 0; k < 3; k++) check("R1", k, '0);

    // exhaustive select/load sweep over several data patterns (R2, R3)
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < 8; s++) begin
        for (int l = 0; l < 8; l++) begin
          preload(W'(p*37 + s*11 + l*5 + 1), W'(p*53 + s*7 + l*3 + 90),
                  W'(p*29 + s*13 + l*17 + 170));
          xfer(3'(s), 3'(l), 1'b0, 2'd0, '0, "");
        end
      end
    end

    // write port against every address and load pattern (R7, R8)
    for (int a = 0; a < 4; a++) begin
      for (int l = 0; l < 8; l++) begin
        preload(8'h11 + W'(l), 8'h42 + W'(a), 8'h83);
        xfer(3'b101, 3'(l), 1'b1, 2'(a), 8'hA5 ^ W'(a*3 + l), "");
      end
    end

    // R4: swap registers 0 and 1
    preload(8'h3C, 8'hC3, 8'h77);
    xfer(3'b000, 3'b011, 1'b0, 2'd0, '0, "R4");
    // R4: rotate 0<-1, 1<-2, 2<-0
    preload(8'h01, 8'h02, 8'h04);
    xfer(3'b010, 3'b111, 1'b0, 2'd0, '0, "R4");
    // R5: register 0 fanned out to registers 1 and 2
    preload(8'h5A, 8'h00, 8'hFF);
    xfer(3'b000, 3'b110, 1'b0, 2'd0, '0, "R5");

    // R1: reset mid-run clears everything
    preload(8'hDE, 8'hAD, 8'hBE);
    rst = 1'b1; load = 3'b111;
    step();
    rst = 1'b0; load = 3'b000;
    for (int k = 0; k < 3; k++) check("R1", k, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule